// File: doc/BRIEF.md
# Memory Access Rule Checker

This block sits in front of a memory port and decides, for every incoming request, whether the request may proceed. It holds a table of twenty protection rules. Each rule names an address window at 1 MiB granularity, an inclusive window of master IDs, a set of ports, a security class and a verdict. A request that carries an address, a master ID, a port number and a secure/non-secure attribute is compared against every rule in parallel. The lowest-numbered rule that matches supplies the verdict. When no rule matches, a per-port default supplies it.

Software never writes a rule directly. It fills three staging registers, which hold the bounds, the IDs and the attributes. It then writes a command word that carries a rule index and either a commit bit or a fetch bit. A commit copies the staging registers into the indexed rule. A fetch copies the indexed rule back into the staging registers, where software can read it.

The verdict is computed combinationally from the request inputs and the rule table. It is registered together with the request valid, so a response appears one clock after the request is sampled.

Top module: `mem_guard`

## Requirements
- R1: After reset every rule is invalid, the per-port default register reads 0, the command register reads 0, `rsp_valid` is low, and every request is accepted.
- R2: Register select 1 (bounds) holds the start block (address bits [31:20]) in bits [11:0] and the end block in bits [23:12]. Register select 2 (IDs) holds the low master ID in bits [11:0] and the high master ID in bits [23:12].
- R3: Register select 3 (attributes) holds the security class in bits [1:0], valid in bit 2, the port mask (bit p is port p) in bits [12:3] and the verdict in bit 13, where 1 means reject and 0 means accept.
- R4: A write to register select 0 (command) with bit 5 set copies the staged bounds, IDs and attributes into the rule indexed by bits [4:0]. The copy takes effect at that clock edge. An index of 20 or more changes no rule.
- R5: A command write with bit 6 set and bit 5 clear loads the indexed rule into the staging registers at that edge. The command register reads back only its index, with bits 5 and 6 reading as 0.
- R6: A rule matches only if it is valid, its port-mask bit for the request port is set, and the request ID lies in [low ID, high ID] inclusive.
- R7: A rule matches only if address bits [31:20] lie in [start block, end block] inclusive.
- R8: A rule matches only if its security class permits the request: class bit 0 admits secure requests and class bit 1 admits non-secure requests.
- R9: When several rules match, the verdict of the lowest-numbered matching rule is used.
- R10: When no rule matches, bit p of the default register (select 4) gives the verdict for port p, with 1 meaning reject. A request on a port number of 10 or more is rejected.
- R11: `rsp_valid` follows `req_valid` by one clock and carries that request's verdict. A commit at the same edge that samples a request does not affect that request's verdict.
- R12: Writing a rule whose fields are all zero disables it, and matching requests then fall through to later rules or to the default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 command, 1 bounds, 2 IDs, 3 attributes, 4 port defaults |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request byte address |
| req_id | input | 12 | Request master ID |
| req_port | input | 4 | Request port number |
| req_secure | input | 1 | 1 for a secure request, 0 for a non-secure request |
| rsp_valid | output | 1 | Verdict present, one clock after `req_valid` |
| rsp_reject | output | 1 | 1 when the request is refused |

## Verification
The bench builds the block with its default parameters: twenty rules, ten ports, 12-bit IDs and a 32-bit address with 1 MiB blocks. At these values an out-of-range rule index (25) and out-of-range port numbers (12) can be expressed, so the ignored-commit and unknown-port paths are reachable. The 12-bit block and ID fields let the bench probe exact inclusive edges such as 0x1FFF_FFFF against 0x2000_0000. Overlapping rules at indices 2, 3 and 7 exercise the priority order, and a commit issued in the same cycle as a request exposes the one-clock visibility boundary.

// File: rtl/mem_guard_pkg.sv
package mem_guard_pkg;
   // register selects on the configuration port
   typedef enum logic [2:0] {
      SEL_CMD    = 3'd0,
      SEL_BOUNDS = 3'd1,
      SEL_IDS    = 3'd2,
      SEL_ATTR   = 3'd3,
      SEL_DFLT   = 3'd4
   } reg_sel_e;

   localparam int CFG_W          = 32;
   localparam int CMD_COMMIT_BIT = 5;
   localparam int CMD_FETCH_BIT  = 6;
   localparam int ATTR_SEC_W     = 2;
   localparam int ATTR_VALID_BIT = 2;
   localparam int ATTR_MASK_LSB  = 3;
endpackage

// File: rtl/mg_cfg_regs.sv
module mg_cfg_regs
   import mem_guard_pkg::*;
#(
   parameter int NUM_RULES = 20,
   parameter int NUM_PORTS = 10,
   parameter int ID_W      = 12,
   parameter int BW        = 12,
   localparam int IDX_W    = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [2:0]           cfg_sel,
   input  logic [CFG_W-1:0]     cfg_wdata,
   output logic [CFG_W-1:0]     cfg_rdata,
   // towards the rule table
   output logic                 tbl_wr,
   output logic [IDX_W-1:0]     tbl_idx,
   output logic [BW-1:0]        st_lo,
   output logic [BW-1:0]        st_hi,
   output logic [ID_W-1:0]      st_idlo,
   output logic [ID_W-1:0]      st_idhi,
   output logic [ATTR_SEC_W-1:0] st_sec,
   output logic                 st_vld,
   output logic [NUM_PORTS-1:0] st_pmask,
   output logic                 st_res,
   input  logic [BW-1:0]        rb_lo,
   input  logic [BW-1:0]        rb_hi,
   input  logic [ID_W-1:0]      rb_idlo,
   input  logic [ID_W-1:0]      rb_idhi,
   input  logic [ATTR_SEC_W-1:0] rb_sec,
   input  logic                 rb_vld,
   input  logic [NUM_PORTS-1:0] rb_pmask,
   input  logic                 rb_res,
   // per-port default verdicts
   output logic [NUM_PORTS-1:0] dflt
);
   localparam int RES_BIT = ATTR_MASK_LSB + NUM_PORTS;

   reg_sel_e         sel;
   logic             cmd_wr, fetch;
   logic [IDX_W-1:0] idx_q;
   logic             unused_wbits;

   assign sel          = reg_sel_e'(cfg_sel);
   assign cmd_wr       = cfg_we && (sel == SEL_CMD);
   assign tbl_idx      = cfg_wdata[IDX_W-1:0];
   assign tbl_wr       = cmd_wr && cfg_wdata[CMD_COMMIT_BIT];
   assign fetch        = cmd_wr && cfg_wdata[CMD_FETCH_BIT] && !cfg_wdata[CMD_COMMIT_BIT];
   assign unused_wbits = ^cfg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q    <= '0;
         st_lo    <= '0;
         st_hi    <= '0;
         st_idlo  <= '0;
         st_idhi  <= '0;
         st_sec   <= '0;
         st_vld   <= 1'b0;
         st_pmask <= '0;
         st_res   <= 1'b0;
         dflt     <= '0;
      end else if (fetch) begin
         idx_q    <= tbl_idx;
         st_lo    <= rb_lo;
         st_hi    <= rb_hi;
         st_idlo  <= rb_idlo;
         st_idhi  <= rb_idhi;
         st_sec   <= rb_sec;
         st_vld   <= rb_vld;
         st_pmask <= rb_pmask;
         st_res   <= rb_res;
      end else if (cfg_we) begin
         unique case (sel)
            SEL_CMD:    idx_q <= tbl_idx;
            SEL_BOUNDS: begin
               st_lo <= cfg_wdata[BW-1:0];
               st_hi <= cfg_wdata[2*BW-1:BW];
            end
            SEL_IDS: begin
               st_idlo <= cfg_wdata[ID_W-1:0];
               st_idhi <= cfg_wdata[2*ID_W-1:ID_W];
            end
            SEL_ATTR: begin
               st_sec   <= cfg_wdata[ATTR_SEC_W-1:0];
               st_vld   <= cfg_wdata[ATTR_VALID_BIT];
               st_pmask <= cfg_wdata[ATTR_MASK_LSB +: NUM_PORTS];
               st_res   <= cfg_wdata[RES_BIT];
            end
            SEL_DFLT:   dflt <= cfg_wdata[NUM_PORTS-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      cfg_rdata = '0;
      unique case (sel)
         SEL_CMD:    cfg_rdata[IDX_W-1:0] = idx_q;
         SEL_BOUNDS: begin
            cfg_rdata[BW-1:0]    = st_lo;
            cfg_rdata[2*BW-1:BW] = st_hi;
         end
         SEL_IDS: begin
            cfg_rdata[ID_W-1:0]      = st_idlo;
            cfg_rdata[2*ID_W-1:ID_W] = st_idhi;
         end
         SEL_ATTR: begin
            cfg_rdata[ATTR_SEC_W-1:0]          = st_sec;
            cfg_rdata[ATTR_VALID_BIT]          = st_vld;
            cfg_rdata[ATTR_MASK_LSB +: NUM_PORTS] = st_pmask;
            cfg_rdata[RES_BIT]                 = st_res;
         end
         SEL_DFLT:   cfg_rdata[NUM_PORTS-1:0] = dflt;
         default:    cfg_rdata = '0;
      endcase
   end

   // staging only moves on a configuration write (R5)
   p_stage_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable({st_lo, st_hi, st_idlo, st_idhi, st_sec, st_vld, st_pmask, st_res}));

   // defaults only move on their own select (R10)
   p_dflt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_sel == 3'd4) |=> $stable(dflt));
endmodule

// File: rtl/mg_rule_table.sv
module mg_rule_table
   import mem_guard_pkg::*;
#(
   parameter int NUM_RULES = 20,
   parameter int NUM_PORTS = 10,
   parameter int ID_W      = 12,
   parameter int BW        = 12,
   localparam int IDX_W    = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr,
   input  logic [IDX_W-1:0]      idx,
   input  logic [BW-1:0]         in_lo,
   input  logic [BW-1:0]         in_hi,
   input  logic [ID_W-1:0]       in_idlo,
   input  logic [ID_W-1:0]       in_idhi,
   input  logic [ATTR_SEC_W-1:0] in_sec,
   input  logic                  in_vld,
   input  logic [NUM_PORTS-1:0]  in_pmask,
   input  logic                  in_res,
   // whole table, for the matcher
   output logic [BW-1:0]         lo_a    [NUM_RULES],
   output logic [BW-1:0]         hi_a    [NUM_RULES],
   output logic [ID_W-1:0]       idlo_a  [NUM_RULES],
   output logic [ID_W-1:0]       idhi_a  [NUM_RULES],
   output logic [ATTR_SEC_W-1:0] sec_a   [NUM_RULES],
   output logic                  vld_a   [NUM_RULES],
   output logic [NUM_PORTS-1:0]  pmask_a [NUM_RULES],
   output logic                  res_a   [NUM_RULES],
   // indexed rule, for the fetch path
   output logic [BW-1:0]         rb_lo,
   output logic [BW-1:0]         rb_hi,
   output logic [ID_W-1:0]       rb_idlo,
   output logic [ID_W-1:0]       rb_idhi,
   output logic [ATTR_SEC_W-1:0] rb_sec,
   output logic                  rb_vld,
   output logic [NUM_PORTS-1:0]  rb_pmask,
   output logic                  rb_res
);
   for (genvar i = 0; i < NUM_RULES; i++) begin : g_slot
      logic hit_me;
      assign hit_me = wr && (idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_a[i]    <= '0;
            hi_a[i]    <= '0;
            idlo_a[i]  <= '0;
            idhi_a[i]  <= '0;
            sec_a[i]   <= '0;
            vld_a[i]   <= 1'b0;
            pmask_a[i] <= '0;
            res_a[i]   <= 1'b0;
         end else if (hit_me) begin
            lo_a[i]    <= in_lo;
            hi_a[i]    <= in_hi;
            idlo_a[i]  <= in_idlo;
            idhi_a[i]  <= in_idhi;
            sec_a[i]   <= in_sec;
            vld_a[i]   <= in_vld;
            pmask_a[i] <= in_pmask;
            res_a[i]   <= in_res;
         end
      end

      // a slot changes only when its own index is committed (R4)
      p_rule_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr && idx == IDX_W'(i)) |=> $stable({lo_a[i], hi_a[i], idlo_a[i], idhi_a[i],
                                               sec_a[i], vld_a[i], pmask_a[i], res_a[i]}));
   end

   always_comb begin
      rb_lo = '0; rb_hi = '0; rb_idlo = '0; rb_idhi = '0;
      rb_sec = '0; rb_vld = 1'b0; rb_pmask = '0; rb_res = 1'b0;
      for (int i = 0; i < NUM_RULES; i++) begin
         if (idx == IDX_W'(i)) begin
            rb_lo    = lo_a[i];
            rb_hi    = hi_a[i];
            rb_idlo  = idlo_a[i];
            rb_idhi  = idhi_a[i];
            rb_sec   = sec_a[i];
            rb_vld   = vld_a[i];
            rb_pmask = pmask_a[i];
            rb_res   = res_a[i];
         end
      end
   end
endmodule

// File: rtl/mg_match.sv
module mg_match
   import mem_guard_pkg::*;
#(
   parameter int NUM_RULES = 20,
   parameter int NUM_PORTS = 10,
   parameter int ID_W      = 12,
   parameter int ADDR_W    = 32,
   parameter int GRAN_LSB  = 20,
   localparam int BW       = ADDR_W - GRAN_LSB,
   localparam int PORT_W   = $clog2(NUM_PORTS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [ID_W-1:0]       req_id,
   input  logic [PORT_W-1:0]     req_port,
   input  logic                  req_secure,
   input  logic [BW-1:0]         lo_a    [NUM_RULES],
   input  logic [BW-1:0]         hi_a    [NUM_RULES],
   input  logic [ID_W-1:0]       idlo_a  [NUM_RULES],
   input  logic [ID_W-1:0]       idhi_a  [NUM_RULES],
   input  logic [ATTR_SEC_W-1:0] sec_a   [NUM_RULES],
   input  logic                  vld_a   [NUM_RULES],
   input  logic [NUM_PORTS-1:0]  pmask_a [NUM_RULES],
   input  logic                  res_a   [NUM_RULES],
   input  logic [NUM_PORTS-1:0]  dflt,
   output logic                  reject
);
   logic [BW-1:0]        blk;
   logic [NUM_PORTS-1:0] port_oh;
   logic [NUM_RULES-1:0] hit, win, res_v;
   logic [NUM_RULES:0]   seen;
   logic                 unused_low;

   assign blk        = req_addr[ADDR_W-1:GRAN_LSB];
   assign unused_low = ^req_addr[GRAN_LSB-1:0];

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign port_oh[p] = (req_port == PORT_W'(p));
   end

   assign seen[0] = 1'b0;
   for (genvar i = 0; i < NUM_RULES; i++) begin : g_cmp
      logic id_in, blk_in, sec_ok, port_in;
      assign id_in   = (req_id >= idlo_a[i]) && (req_id <= idhi_a[i]);
      assign blk_in  = (blk >= lo_a[i]) && (blk <= hi_a[i]);
      assign sec_ok  = req_secure ? sec_a[i][0] : sec_a[i][1];
      assign port_in = |(pmask_a[i] & port_oh);
      assign hit[i]  = vld_a[i] && port_in && id_in && blk_in && sec_ok;
      // first hit wins: ripple a "seen" flag from rule 0 upward
      assign win[i]     = hit[i] && !seen[i];
      assign seen[i+1]  = seen[i] || hit[i];
      assign res_v[i]   = res_a[i];
   end

   always_comb begin
      if (seen[NUM_RULES])  reject = |(win & res_v);
      else if (|port_oh)    reject = |(dflt & port_oh);
      else                  reject = 1'b1;
   end

   // at most one deciding rule (R9)
   p_single_win_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win));

   // any matching rule produces a deciding rule (R9)
   p_hit_has_win_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |-> (win != '0));
endmodule

// File: rtl/mem_guard.sv
module mem_guard
   import mem_guard_pkg::*;
#(
   parameter int NUM_RULES = 20,
   parameter int NUM_PORTS = 10,
   parameter int ID_W      = 12,
   parameter int ADDR_W    = 32,
   parameter int GRAN_LSB  = 20,
   localparam int BW       = ADDR_W - GRAN_LSB,
   localparam int PORT_W   = $clog2(NUM_PORTS),
   localparam int IDX_W    = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ID_W-1:0]   req_id,
   input  logic [PORT_W-1:0] req_port,
   input  logic              req_secure,
   output logic              rsp_valid,
   output logic              rsp_reject
);
   // elaboration-time parameter checks
   if (NUM_RULES < 1 || IDX_W > CMD_COMMIT_BIT) begin : g_bad_rules
      $error("mem_guard: rule count must fit below the command bits");
   end
   if (2 * BW > CFG_W || GRAN_LSB < 1) begin : g_bad_bounds
      $error("mem_guard: two block fields must fit one register");
   end
   if (2 * ID_W > CFG_W) begin : g_bad_ids
      $error("mem_guard: two ID fields must fit one register");
   end
   if (NUM_PORTS < 2 || ATTR_MASK_LSB + NUM_PORTS + 1 > CFG_W) begin : g_bad_ports
      $error("mem_guard: port mask and verdict must fit one register");
   end

   logic                  tbl_wr, verdict;
   logic [IDX_W-1:0]      tbl_idx;
   logic [BW-1:0]         st_lo, st_hi, rb_lo, rb_hi;
   logic [ID_W-1:0]       st_idlo, st_idhi, rb_idlo, rb_idhi;
   logic [ATTR_SEC_W-1:0] st_sec, rb_sec;
   logic                  st_vld, st_res, rb_vld, rb_res;
   logic [NUM_PORTS-1:0]  st_pmask, rb_pmask, dflt;
   logic [BW-1:0]         lo_a    [NUM_RULES];
   logic [BW-1:0]         hi_a    [NUM_RULES];
   logic [ID_W-1:0]       idlo_a  [NUM_RULES];
   logic [ID_W-1:0]       idhi_a  [NUM_RULES];
   logic [ATTR_SEC_W-1:0] sec_a   [NUM_RULES];
   logic                  vld_a   [NUM_RULES];
   logic [NUM_PORTS-1:0]  pmask_a [NUM_RULES];
   logic                  res_a   [NUM_RULES];

   mg_cfg_regs #(.NUM_RULES(NUM_RULES), .NUM_PORTS(NUM_PORTS), .ID_W(ID_W), .BW(BW)) u_regs (
      .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .cfg_rdata,
      .tbl_wr, .tbl_idx,
      .st_lo, .st_hi, .st_idlo, .st_idhi, .st_sec, .st_vld, .st_pmask, .st_res,
      .rb_lo, .rb_hi, .rb_idlo, .rb_idhi, .rb_sec, .rb_vld, .rb_pmask, .rb_res,
      .dflt
   );

   mg_rule_table #(.NUM_RULES(NUM_RULES), .NUM_PORTS(NUM_PORTS), .ID_W(ID_W), .BW(BW)) u_table (
      .clk, .rst_n, .wr(tbl_wr), .idx(tbl_idx),
      .in_lo(st_lo), .in_hi(st_hi), .in_idlo(st_idlo), .in_idhi(st_idhi),
      .in_sec(st_sec), .in_vld(st_vld), .in_pmask(st_pmask), .in_res(st_res),
      .lo_a, .hi_a, .idlo_a, .idhi_a, .sec_a, .vld_a, .pmask_a, .res_a,
      .rb_lo, .rb_hi, .rb_idlo, .rb_idhi, .rb_sec, .rb_vld, .rb_pmask, .rb_res
   );

   mg_match #(.NUM_RULES(NUM_RULES), .NUM_PORTS(NUM_PORTS), .ID_W(ID_W),
              .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_match (
      .clk, .rst_n, .req_addr, .req_id, .req_port, .req_secure,
      .lo_a, .hi_a, .idlo_a, .idhi_a, .sec_a, .vld_a, .pmask_a, .res_a,
      .dflt, .reject(verdict)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_reject <= 1'b0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_reject <= req_valid && verdict;
      end
   end

   // response handshake trails the request by one clock (R11)
   p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid && !rsp_reject);

   // unknown port numbers are refused (R10)
   p_port_oob_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && int'(req_port) >= NUM_PORTS) |=> rsp_reject);
endmodule

// File: tb/mem_guard_test.sv
module mem_guard_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = 3'd0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [11:0] req_id = '0;
   logic [3:0]  req_port = '0;
   logic        req_secure = 1'b0;
   logic        rsp_valid, rsp_reject;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   mem_guard uut (
      .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .cfg_rdata,
      .req_valid, .req_addr, .req_id, .req_port, .req_secure,
      .rsp_valid, .rsp_reject
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [2:0] sel, input logic [31:0] exp);
      @(negedge clk);
      cfg_sel = sel;
      #2 chk(tag, cfg_rdata, exp);
   endtask

   function automatic logic [31:0] attr(input logic [1:0] sec, input logic vld,
                                        input logic [9:0] pm, input logic res);
      return {18'd0, res, pm, vld, sec};
   endfunction

   task automatic put_rule(input int idx, input logic [11:0] lo, input logic [11:0] hi,
                           input logic [11:0] il, input logic [11:0] ih, input logic [31:0] a);
      reg_wr(3'd1, {8'd0, hi, lo});
      reg_wr(3'd2, {8'd0, ih, il});
      reg_wr(3'd3, a);
      reg_wr(3'd0, 32'(idx) | 32'h20);
   endtask

   task automatic probe(input string tag, input logic [31:0] a, input logic [11:0] id,
                        input logic [3:0] port, input logic sec, input logic exp_rej);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_id = id; req_port = port; req_secure = sec;
      @(negedge clk);
      chk({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
      chk({tag, " verdict"}, {31'd0, rsp_reject}, {31'd0, exp_rej});
      req_valid = 1'b0;
   endtask

   task automatic wipe();
      for (int r = 0; r < 20; r++) put_rule(r, 12'h0, 12'h0, 12'h0, 12'h0, 32'h0);
      reg_wr(3'd4, 32'h0);
   endtask

   localparam logic [31:0] OPEN_SEC = 32'h3FF << 3 | 32'h7;   // all ports, valid, both classes

   task automatic t_reset();
      chk("R1 rsp_valid low", {31'd0, rsp_valid}, 32'd0);
      rd_chk("R1 default reg", 3'd4, 32'h0);
      rd_chk("R1 cmd reg", 3'd0, 32'h0);
      probe("R1 empty table accepts", 32'h8000_0000, 12'h123, 4'd7, 1'b0, 1'b0);
   endtask

   task automatic t_basic();
      reg_wr(3'd4, 32'h3FF);
      put_rule(0, 12'h000, 12'h0FF, 12'h000, 12'hFFF, OPEN_SEC);
      probe("R6 inside accepted", 32'h0FF0_0000, 12'h001, 4'd0, 1'b1, 1'b0);
      probe("R10 unmatched default reject", 32'h1000_0000, 12'h001, 4'd0, 1'b1, 1'b1);
      wipe();
   endtask

   task automatic t_ports_ids();
      reg_wr(3'd4, 32'h3FF);
      put_rule(1, 12'h000, 12'hFFF, 12'h010, 12'h020, attr(2'b11, 1'b1, 10'h004, 1'b0));
      probe("R6 id low edge", 32'h0, 12'h010, 4'd2, 1'b0, 1'b0);
      probe("R6 id high edge", 32'h0, 12'h020, 4'd2, 1'b0, 1'b0);
      probe("R6 id above", 32'h0, 12'h021, 4'd2, 1'b0, 1'b1);
      probe("R6 id below", 32'h0, 12'h00F, 4'd2, 1'b0, 1'b1);
      probe("R6 port not in mask", 32'h0, 12'h015, 4'd3, 1'b0, 1'b1);
      wipe();
   endtask

   task automatic t_addr_edges();
      reg_wr(3'd4, 32'h3FF);
      put_rule(0, 12'h100, 12'h1FF, 12'h000, 12'hFFF, OPEN_SEC);
      probe("R7 start edge", 32'h1000_0000, 12'h0, 4'd1, 1'b1, 1'b0);
      probe("R7 end edge", 32'h1FFF_FFFF, 12'h0, 4'd1, 1'b1, 1'b0);
      probe("R7 below start", 32'h0FFF_FFFF, 12'h0, 4'd1, 1'b1, 1'b1);
      probe("R7 above end", 32'h2000_0000, 12'h0, 4'd1, 1'b1, 1'b1);
      wipe();
   endtask

   task automatic t_security();
      reg_wr(3'd4, 32'h3FF);
      put_rule(0, 12'h000, 12'hFFF, 12'h000, 12'hFFF, attr(2'b01, 1'b1, 10'h3FF, 1'b0));
      probe("R8 class1 secure", 32'h4000_0000, 12'h5, 4'd0, 1'b1, 1'b0);
      probe("R8 class1 nonsecure", 32'h4000_0000, 12'h5, 4'd0, 1'b0, 1'b1);
      put_rule(0, 12'h000, 12'hFFF, 12'h000, 12'hFFF, attr(2'b10, 1'b1, 10'h3FF, 1'b0));
      probe("R8 class2 secure", 32'h4000_0000, 12'h5, 4'd0, 1'b1, 1'b1);
      probe("R8 class2 nonsecure", 32'h4000_0000, 12'h5, 4'd0, 1'b0, 1'b0);
      put_rule(0, 12'h000, 12'hFFF, 12'h000, 12'hFFF, attr(2'b00, 1'b1, 10'h3FF, 1'b0));
      probe("R8 class0 secure", 32'h4000_0000, 12'h5, 4'd0, 1'b1, 1'b1);
      wipe();
   endtask

   task automatic t_priority();
      put_rule(3, 12'h000, 12'hFFF, 12'h000, 12'hFFF, attr(2'b11, 1'b1, 10'h3FF, 1'b1));
      put_rule(7, 12'h000, 12'hFFF, 12'h000, 12'hFFF, attr(2'b11, 1'b1, 10'h3FF, 1'b0));
      probe("R9 rule3 over rule7", 32'h0, 12'h0, 4'd5, 1'b0, 1'b1);
      put_rule(2, 12'h000, 12'hFFF, 12'h000, 12'hFFF, attr(2'b11, 1'b1, 10'h3DF, 1'b0));
      probe("R9 rule2 over rule3", 32'h0, 12'h0, 4'd4, 1'b0, 1'b0);
      probe("R9 rule2 skips port5", 32'h0, 12'h0, 4'd5, 1'b0, 1'b1);
      wipe();
   endtask

   task automatic t_readback();
      put_rule(7, 12'h123, 12'hABC, 12'h045, 12'h9EF, attr(2'b10, 1'b1, 10'h2A5, 1'b1));
      reg_wr(3'd1, 32'h0);
      reg_wr(3'd2, 32'h0);
      reg_wr(3'd3, 32'h0);
      reg_wr(3'd0, 32'h47);
      rd_chk("R2 bounds fetched", 3'd1, 32'h00AB_C123);
      rd_chk("R2 ids fetched", 3'd2, 32'h009E_F045);
      rd_chk("R3 attributes fetched", 3'd3, 32'h0000_352E);
      rd_chk("R5 cmd bits self-clear", 3'd0, 32'h7);
      wipe();
   endtask

   task automatic t_clear_oob();
      put_rule(25, 12'h000, 12'hFFF, 12'h000, 12'hFFF, attr(2'b11, 1'b1, 10'h3FF, 1'b1));
      probe("R4 index 25 ignored", 32'h0, 12'h0, 4'd0, 1'b0, 1'b0);
      put_rule(0, 12'h000, 12'hFFF, 12'h000, 12'hFFF, attr(2'b11, 1'b1, 10'h3FF, 1'b1));
      probe("R4 rule0 reject", 32'h0, 12'h0, 4'd0, 1'b0, 1'b1);
      put_rule(0, 12'h0, 12'h0, 12'h0, 12'h0, 32'h0);
      probe("R12 zero rule disabled", 32'h0, 12'h0, 4'd0, 1'b0, 1'b0);
   endtask

   task automatic t_defaults();
      reg_wr(3'd4, 32'h010);
      probe("R10 port4 default reject", 32'h0, 12'h0, 4'd4, 1'b1, 1'b1);
      probe("R10 port5 default accept", 32'h0, 12'h0, 4'd5, 1'b1, 1'b0);
      probe("R10 port12 refused", 32'h0, 12'h0, 4'd12, 1'b1, 1'b1);
      reg_wr(3'd4, 32'h0);
   endtask

   task automatic t_midstream();
      reg_wr(3'd1, 32'h00FF_F000);
      reg_wr(3'd2, 32'h00FF_F000);
      reg_wr(3'd3, attr(2'b11, 1'b1, 10'h3FF, 1'b1));
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 32'h20;
      req_valid = 1'b1; req_addr = 32'h0; req_id = 12'h0; req_port = 4'd0; req_secure = 1'b0;
      @(negedge clk);
      cfg_we = 1'b0;
      chk("R11 same-edge request uses old table", {31'd0, rsp_reject}, 32'd0);
      req_valid = 1'b0;
      @(negedge clk);
      chk("R11 rsp_valid drops", {31'd0, rsp_valid}, 32'd0);
      probe("R11 next request sees commit", 32'h0, 12'h0, 4'd0, 1'b0, 1'b1);
      wipe();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_ports_ids();
      t_addr_edges();
      t_security();
      t_priority();
      t_readback();
      t_clear_oob();
      t_defaults();
      t_midstream();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule